// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits between a serial memory's bus decoder and its storage array. It gathers the data bytes of one write transaction into a small page buffer. When the transaction closes, it commits the bytes to storage and then holds a busy flag for a fixed, timed write interval. The decoder supplies three strobes: one for a transaction start, which carries the target address; one for each received byte; and one for the closing stop. The storage side sees an ordinary one-port write interface: address, data and enable.

The buffer holds one page of `PAGE_BYTES` entries. The start address picks both the page and the first column. Each received byte goes into the current column, and the column then advances. The column wraps inside the page, so a transaction longer than one page overwrites its own earlier bytes, and the page never changes. A per-column loaded mask records which entries hold data, so the commit writes only those entries. While busy is high the decoder is expected to withhold acknowledges. The block also ignores every strobe on its own, so a polling or misbehaving controller cannot disturb a commit in progress.

Top module: `page_write_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o` and `mem_we_o` are low until a write cycle is started.
- R2: A start strobe latches the page from the upper address bits and the column from the low four bits. Each byte strobe stores the byte at the current column and then advances the column by one. The byte is later written to address {page, column}.
- R3: The column counts modulo 16 and the page bits never change within a transaction. A byte that lands on an already loaded column replaces the earlier byte.
- R4: A commit writes only the columns loaded since the last start. The number of write strobes equals the number of distinct columns loaded.
- R5: Commit writes come one per clock in ascending column order, starting in the first busy cycle. `mem_we_o` is never high unless `busy_o` is high.
- R6: A stop strobe that follows at least one stored byte raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `WR_CYCLES` cycles.
- R7: While `busy_o` is high, start, byte and stop strobes have no effect. After the cycle ends, the page and the column are those left by the committed transaction, and the loaded mask is empty.
- R8: A stop strobe with no byte stored since the last start or commit starts no write cycle and issues no writes.
- R9: A start strobe during an unfinished transaction discards all bytes loaded before it.
- R10: If strobes coincide, start takes priority over stop, and stop takes priority over byte. A byte that coincides with a start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start strobe |
| base_addr_i | input | ADDR_W | Start address, sampled with `start_i` |
| byte_vld_i | input | 1 | Received data byte strobe |
| byte_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Transaction stop, commit request |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Storage write enable |
| mem_addr_o | output | ADDR_W | Storage write address |
| mem_data_o | output | DATA_W | Storage write data |

## Verification
The hardest case to reach from the ports is a strobe that arrives during the scan phase of a commit. Such a strobe could rewrite a buffer entry, or move the page or the column, while that entry is being written out. To provoke it, the stimulus drives a start to a foreign page, a run of byte strobes and a second stop while the first busy cycles are still emitting writes. It then sends one more byte without a new start. Because that byte's write address reveals the page and column held after the commit, any leak of the ignored strobes shows up at the ports. A 20-byte transaction that starts mid-page covers wrap and overwrite. A start that coincides with a byte strobe covers the priority rule.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_COMMIT  = 1'b1
  } pws_phase_e;
endpackage

// File: rtl/pws_col_track.sv
module pws_col_track #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic [ADDR_W-1:0]                  base_i,
  input  logic                               store_i,
  input  logic                               clear_i,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_o,
  output logic [$clog2(PAGE_BYTES)-1:0]      col_o,
  output logic [PAGE_BYTES-1:0]              mask_o
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic [PAGE_W-1:0]     page_q, page_d;
  logic [COL_W-1:0]      col_q, col_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic                  en;

  assign en = load_i | store_i | clear_i;

  always_comb begin
    page_d = page_q;
    col_d  = col_q;
    mask_d = mask_q;
    if (load_i) begin
      page_d = base_i[ADDR_W-1:COL_W];
      col_d  = base_i[COL_W-1:0];
      mask_d = '0;
    end else begin
      if (store_i) begin
        mask_d[col_q] = 1'b1;
        col_d         = col_q + 1'b1;
      end
      if (clear_i) mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
      mask_q <= '0;
    end else if (en) begin
      page_q <= page_d;
      col_q  <= col_d;
      mask_q <= mask_d;
    end
  end

  assign page_o = page_q;
  assign col_o  = col_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          wr_en_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_col_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_col_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic [PAGE_BYTES*DATA_W-1:0] flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    logic              en;
    assign en = wr_en_i && (wr_col_i == COL_W'(g));
    always_ff @(posedge clk) begin
      if (en) q <= wr_data_i;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  assign rd_data_o = flat[int'(rd_col_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer
  import pws_pkg::*;
#(
  parameter int CYCLES     = 40,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_i,
  output logic                          busy_o,
  output logic                          scan_vld_o,
  output logic [$clog2(PAGE_BYTES)-1:0] scan_col_o,
  output logic                          done_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(CYCLES + 1);

  pws_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              last;
  logic              en;

  assign last = (phase_q == PH_COMMIT) && (cnt_q == CNT_W'(CYCLES - 1));
  assign en   = go_i | (phase_q == PH_COMMIT);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_COLLECT: begin
        if (go_i) begin
          phase_d = PH_COMMIT;
          cnt_d   = '0;
        end
      end
      PH_COMMIT: begin
        if (last) begin
          phase_d = PH_COLLECT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_COLLECT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_COLLECT;
      cnt_q   <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o     = (phase_q == PH_COMMIT);
  assign scan_vld_o = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_col_o = cnt_q[COL_W-1:0];
  assign done_o     = last;
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                  busy;
  logic                  accept;
  logic                  load_g, store_g, stop_g, go;
  logic                  scan_vld, done;
  logic [COL_W-1:0]      scan_col, col;
  logic [PAGE_W-1:0]     page;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rd_data;

  // strobes are accepted only outside the write cycle; start > stop > byte
  assign accept  = ~busy;
  assign load_g  = accept & start_i;
  assign stop_g  = accept & stop_i & ~start_i;
  assign store_g = accept & byte_vld_i & ~start_i & ~stop_i;
  assign go      = stop_g & (|mask);

  pws_col_track #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (load_g),
    .base_i  (base_addr_i),
    .store_i (store_g),
    .clear_i (done),
    .page_o  (page),
    .col_o   (col),
    .mask_o  (mask)
  );

  pws_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_buf (
    .clk       (clk),
    .wr_en_i   (store_g),
    .wr_col_i  (col),
    .wr_data_i (byte_i),
    .rd_col_i  (scan_col),
    .rd_data_o (rd_data)
  );

  pws_cycle_timer #(
    .CYCLES     (WR_CYCLES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .go_i       (go),
    .busy_o     (busy),
    .scan_vld_o (scan_vld),
    .scan_col_o (scan_col),
    .done_o     (done)
  );

  assign busy_o     = busy;
  assign mem_we_o   = scan_vld & mask[scan_col];
  assign mem_addr_o = {page, scan_col};
  assign mem_data_o = rd_data;
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R5: storage is written only inside the busy interval
  p_we_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  // R5: back-to-back writes move to a higher column
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[COL_W-1:0] > $past(mem_addr_o[COL_W-1:0])));

  // R6: a write cycle begins only after an accepted stop
  p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_i) && !$past(start_i)));

  // R6: the busy interval has the configured length
  p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == WR_CYCLES));

  // R3: the page part of the write address holds during a commit
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:COL_W]));
endmodule

bind page_write_seq pws_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_pws_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/tb_page_write_seq.sv
`timescale 1ns/1ps
module tb_page_write_seq;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int PB  = 16;
  localparam int WRC = 40;

  localparam int NV = 5;
  localparam logic [AW-1:0] VA [NV] = '{11'h000, 11'h123, 11'h2FE, 11'h450, 11'h7F8};
  localparam int            VN [NV] = '{1, 3, 4, 16, 20};
  localparam logic [DW-1:0] VS [NV] = '{8'h11, 8'hA0, 8'h3C, 8'h80, 8'hC1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, byte_vld_i, stop_i;
  logic [AW-1:0] base_addr_i;
  logic [DW-1:0] byte_i;
  logic          busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;

  always #2 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .stop_i(stop_i), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o));

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] lg_a [64];
  logic [DW-1:0] lg_d [64];
  int            lg_n = 0;

  always @(negedge clk) begin
    if (mem_we_o === 1'b1 && lg_n < 64) begin
      lg_a[lg_n] = mem_addr_o;
      lg_d[lg_n] = mem_data_o;
      lg_n++;
    end
  end

  logic [PB-1:0] m_mask;
  logic [DW-1:0] m_buf [PB];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic send_start(input logic [AW-1:0] a);
    start_i = 1'b1; base_addr_i = a; cyc(); start_i = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] d);
    byte_vld_i = 1'b1; byte_i = d; cyc(); byte_vld_i = 1'b0;
  endtask

  // stop, then count the negedges at which busy is seen high
  task automatic commit(output int blen, output bit first_we);
    lg_n = 0;
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    first_we = mem_we_o;
    blen = 0;
    if (busy_o === 1'b1) blen = 1;
    while (busy_o === 1'b1 && blen < 1000) begin
      cyc();
      if (busy_o === 1'b1) blen++;
    end
  endtask

  // compare the write log against the model buffer, ascending columns
  task automatic verify(input logic [AW-5:0] page, input string req);
    int k = 0;
    chk(lg_n == $countones(m_mask), {req, " R4 write count"}, lg_n, $countones(m_mask));
    for (int c = 0; c < PB; c++) begin
      if (m_mask[c]) begin
        if (k < lg_n) begin
          chk(lg_a[k] == {page, 4'(c)}, {req, " R5 address order"}, lg_a[k], {page, 4'(c)});
          chk(lg_d[k] == m_buf[c], {req, " R2 data"}, lg_d[k], m_buf[c]);
        end
        k++;
      end
    end
  endtask

  initial begin : main
    int blen;
    bit fw;
    logic [3:0] col;
    bit seen;
    rst_n = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
    base_addr_i = '0; byte_i = '0;
    repeat (3) cyc();
    chk(busy_o === 1'b0 && mem_we_o === 1'b0, "R1 in reset", {busy_o, mem_we_o}, 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(busy_o === 1'b0 && mem_we_o === 1'b0, "R1 after reset", {busy_o, mem_we_o}, 0);

    // vector table: base address, byte count, data seed
    for (int v = 0; v < NV; v++) begin
      m_mask = '0;
      col = VA[v][3:0];
      send_start(VA[v]);
      for (int i = 0; i < VN[v]; i++) begin
        send_byte(VS[v] + 8'(i));
        m_buf[col] = VS[v] + 8'(i);
        m_mask[col] = 1'b1;
        col = col + 4'd1;
      end
      commit(blen, fw);
      chk(blen == WRC, "R6 busy length", blen, WRC);
      chk(fw == m_mask[0], "R5 first write in first busy cycle", fw, m_mask[0]);
      verify(VA[v][AW-1:4], (VN[v] > 16 || VA[v][3:0] + VN[v] > 16) ? "R3 wrap" : "R2 fill");
    end

    // R8: stop with nothing stored
    send_start(11'h100);
    lg_n = 0;
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    seen = 1'b0;
    for (int j = 0; j < 6; j++) begin
      if (busy_o !== 1'b0 || mem_we_o !== 1'b0) seen = 1'b1;
      cyc();
    end
    chk(!seen && lg_n == 0, "R8 empty stop", {seen, 8'(lg_n)}, 0);

    // R10: byte coinciding with start is dropped, so stop finds nothing
    start_i = 1'b1; base_addr_i = 11'h500; byte_vld_i = 1'b1; byte_i = 8'h99;
    cyc();
    start_i = 1'b0; byte_vld_i = 1'b0;
    lg_n = 0;
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    seen = 1'b0;
    for (int j = 0; j < 6; j++) begin
      if (busy_o !== 1'b0) seen = 1'b1;
      cyc();
    end
    chk(!seen && lg_n == 0, "R10 start over byte", {seen, 8'(lg_n)}, 0);

    // R9: restart discards earlier bytes
    send_start(11'h300);
    send_byte(8'h10);
    send_byte(8'h11);
    send_start(11'h3A5);
    send_byte(8'h77);
    m_mask = '0; m_mask[5] = 1'b1; m_buf[5] = 8'h77;
    commit(blen, fw);
    chk(blen == WRC, "R9 busy length", blen, WRC);
    verify(7'h3A, "R9 restart");

    // R7: strobes during the commit are ignored
    send_start(11'h123);
    send_byte(8'h21);
    send_byte(8'h22);
    send_byte(8'h23);
    m_mask = '0;
    m_mask[3] = 1'b1; m_buf[3] = 8'h21;
    m_mask[4] = 1'b1; m_buf[4] = 8'h22;
    m_mask[5] = 1'b1; m_buf[5] = 8'h23;
    lg_n = 0;
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    chk(busy_o === 1'b1, "R6 busy rise", busy_o, 1);
    blen = (busy_o === 1'b1) ? 1 : 0;
    for (int j = 0; j < 8; j++) begin
      start_i = (j == 0);
      base_addr_i = 11'h6F0;
      byte_vld_i = (j > 0 && j < 7);
      byte_i = 8'hEE;
      stop_i = (j == 7);
      cyc();
      if (busy_o === 1'b1) blen++;
    end
    start_i = 1'b0; byte_vld_i = 1'b0; stop_i = 1'b0;
    while (busy_o === 1'b1 && blen < 1000) begin
      cyc();
      if (busy_o === 1'b1) blen++;
    end
    chk(blen == WRC, "R7 busy length unchanged", blen, WRC);
    verify(7'h12, "R7 buffer untouched");
    // no new start: page and column must continue from the committed transaction
    send_byte(8'h5A);
    m_mask = '0; m_mask[6] = 1'b1; m_buf[6] = 8'h5A;
    commit(blen, fw);
    chk(blen == WRC, "R7 follow-up busy length", blen, WRC);
    verify(7'h12, "R7 page and column kept");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule